// File: doc/BRIEF.md
# Receive Line Condition Monitor

This block sits on the receive side of a T1/E1 port. It checks the dual-rail line data, which the recovered receive clock samples, for three line conditions. The first is loss of signal, meaning a long run of zeros. The second is an unframed all-ones alarm (AIS). The third is loss of the receive clock itself. A free-running reference clock is the timebase for judging clock loss. That same clock also carries the host-facing event bits.

Each condition drives a real-time status output. Each also drives a sticky event bit, which is set when the condition starts. Every event bit has a dedicated clear input, so reading an event bit never clears it. Two configuration inputs select the zero-run threshold and switch the line input between bipolar and NRZ format. Framing, line-code decoding, error counters and interrupt generation are handled elsewhere.

Top module: `rx_line_mon`

## Requirements
- R1: With `cfg_long_run` = 0, `los_rt` rises on the receive clock edge that samples the 255th consecutive zero bit. It is low for every shorter run.
- R2: With `cfg_long_run` = 1, `los_rt` rises on the edge that samples the 2048th consecutive zero bit. It is low for every shorter run.
- R3: In bipolar mode (`cfg_nrz` = 0), a bit is a one when either rail is high. A one on either rail clears `los_rt` on the same sampling edge and restarts the zero run.
- R4: In NRZ mode (`cfg_nrz` = 1), only `rx_pos` carries data and `rx_neg` is ignored. A bit with `rx_pos` = 0 counts as zero whatever `rx_neg` does.
- R5: Received bits are grouped into consecutive 2048-bit windows that start after reset. `ais_rt` changes only at the end of a window. It is set there when the window held fewer than 3 zero bits.
- R6: `ais_rt` is cleared at the end of any window that held 3 or more zero bits.
- R7: `lorc_rt` rises when the receive clock has not toggled for one channel time. One channel time is 8 bit periods, which is `CHAN_BITS`*`REF_PER_BIT` = 32 reference cycles. `lorc_rt` falls within a few reference cycles of the receive clock toggling again.
- R8: Each event bit (`los_evt`, `ais_evt`, `lorc_evt`) sets on the rising edge of its condition, as seen in the reference domain. It then stays set until cleared.
- R9: A one on a clear input clears only its own event bit. When a clear and a new rising edge of the same condition fall in one reference cycle, the bit remains set.
- R10: After reset every status and event output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; timebase for clock loss and event bits |
| rx_clk | input | 1 | Recovered receive clock; samples line data on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| cfg_long_run | input | 1 | 0: loss-of-signal after 255 zeros; 1: after 2048 zeros |
| cfg_nrz | input | 1 | 0: bipolar dual-rail input; 1: NRZ data on rx_pos only |
| rx_pos | input | 1 | Positive rail (NRZ data in NRZ mode) |
| rx_neg | input | 1 | Negative rail (ignored in NRZ mode) |
| los_clr | input | 1 | Clears los_evt (reference domain) |
| ais_clr | input | 1 | Clears ais_evt (reference domain) |
| lorc_clr | input | 1 | Clears lorc_evt (reference domain) |
| los_rt | output | 1 | Real-time loss of signal (receive domain) |
| ais_rt | output | 1 | Real-time all-ones alarm (receive domain) |
| lorc_rt | output | 1 | Real-time loss of receive clock (reference domain) |
| los_evt | output | 1 | Latched loss-of-signal event |
| ais_evt | output | 1 | Latched all-ones alarm event |
| lorc_evt | output | 1 | Latched receive clock loss event |

## Verification
The assertions assume three things about the inputs. First, the two configuration inputs stay fixed while a zero run is in progress. Second, the clear inputs are synchronous to the reference clock. Third, the reference clock runs several times faster than the receive bit rate, so every receive clock toggle is seen across the synchronizer.

The stimulus respects these assumptions in the following ways:
- It changes configuration only after driving a one.
- It drives the clear inputs on reference clock falling edges.
- It keeps a fixed 4:1 clock ratio.
- It stops the receive clock only for whole pauses, either clearly shorter or clearly longer than one channel time.

Tests that depend on AIS windows never assume where a window starts. They use zero bursts whose effect is the same at any window alignment.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
  localparam int unsigned NUM_COND = 3;

  typedef enum logic [1:0] {
    COND_LOS  = 2'd0,
    COND_AIS  = 2'd1,
    COND_LORC = 2'd2
  } cond_e;
endpackage

// File: rtl/lcm_rst_sync.sv
module lcm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lcm_bit_sync.sv
module lcm_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign q = sync_q[STAGES-1];
endmodule

// File: rtl/lcm_zero_run.sv
module lcm_zero_run #(
  parameter int unsigned SHORT_RUN = 255,
  parameter int unsigned LONG_RUN  = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_zero,
  input  logic long_sel,
  output logic los
);
  localparam int unsigned CW = $clog2(LONG_RUN + 1);

  logic [CW-1:0] run_q, run_d;
  logic [CW-1:0] limit;
  logic          los_q, los_d;

  always_comb begin
    limit = long_sel ? CW'(LONG_RUN) : CW'(SHORT_RUN);
    run_d = run_q;
    los_d = los_q;
    if (bit_zero) begin
      if (run_q != CW'(LONG_RUN)) run_d = run_q + CW'(1);
      los_d = (run_d >= limit);
    end else begin
      run_d = '0;
      los_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      los_q <= 1'b0;
    end else begin
      run_q <= run_d;
      los_q <= los_d;
    end
  end

  assign los = los_q;

  a_r3_los_drops_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_zero |=> !los);
  a_r1_los_rises_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(bit_zero));
endmodule

// File: rtl/lcm_ais_det.sv
module lcm_ais_det #(
  parameter int unsigned WIN   = 2048,
  parameter int unsigned ZMAX  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_zero,
  output logic ais
);
  localparam int unsigned WW = $clog2(WIN);
  localparam int unsigned ZW = $clog2(ZMAX + 1);

  logic [WW-1:0] win_q, win_d;
  logic [ZW-1:0] zc_q, zc_d, zc_sum;
  logic          ais_q, ais_d;
  logic          win_end;

  always_comb begin
    win_end = (win_q == WW'(WIN - 1));
    zc_sum  = zc_q;
    if (bit_zero && (zc_q != ZW'(ZMAX))) zc_sum = zc_q + ZW'(1);
    if (win_end) begin
      win_d = '0;
      zc_d  = '0;
      ais_d = (zc_sum < ZW'(ZMAX));
    end else begin
      win_d = win_q + WW'(1);
      zc_d  = zc_sum;
      ais_d = ais_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      zc_q  <= '0;
      ais_q <= 1'b0;
    end else begin
      win_q <= win_d;
      zc_q  <= zc_d;
      ais_q <= ais_d;
    end
  end

  assign ais = ais_q;

  a_r5_ais_moves_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ais) |-> $past(win_end));
  a_r6_zero_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_end) |-> (zc_q <= ZW'(1)));
endmodule

// File: rtl/lcm_clk_watch.sv
module lcm_clk_watch #(
  parameter int unsigned LIMIT = 32
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic rx_clk,
  input  logic rx_rst_n,
  output logic lorc
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic          tgl_q, tgl_d;
  logic          tgl_s, tgl_s_q;
  logic          act;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lorc_q, lorc_d;

  always_comb tgl_d = ~tgl_q;

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) tgl_q <= 1'b0;
    else           tgl_q <= tgl_d;
  end

  lcm_bit_sync #(.STAGES(2)) u_tgl_sync (
    .clk   (ref_clk),
    .rst_n (ref_rst_n),
    .d     (tgl_q),
    .q     (tgl_s)
  );

  always_comb begin
    act   = tgl_s ^ tgl_s_q;
    cnt_d = cnt_q;
    if (act) begin
      cnt_d  = '0;
      lorc_d = 1'b0;
    end else begin
      if (cnt_q != CW'(LIMIT)) cnt_d = cnt_q + CW'(1);
      lorc_d = (cnt_d == CW'(LIMIT));
    end
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      tgl_s_q <= 1'b0;
      cnt_q   <= '0;
      lorc_q  <= 1'b0;
    end else begin
      tgl_s_q <= tgl_s;
      cnt_q   <= cnt_d;
      lorc_q  <= lorc_d;
    end
  end

  assign lorc = lorc_q;

  a_r7_activity_clears: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    act |=> !lorc);
  a_r7_rise_after_silence: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(lorc) |-> !$past(act));
endmodule

// File: rtl/lcm_evt_latch.sv
module lcm_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic evt
);
  logic cond_q;
  logic rise;
  logic evt_q, evt_d;

  always_comb begin
    rise  = cond & ~cond_q;
    evt_d = rise | (evt_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      evt_q  <= evt_d;
    end
  end

  assign evt = evt_q;

  a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> evt);
  a_r9_holds_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !clr) |=> evt);
  a_r9_clear_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise) |=> !evt);
endmodule

// File: rtl/rx_line_mon.sv
module rx_line_mon #(
  parameter int unsigned SHORT_RUN   = 255,
  parameter int unsigned LONG_RUN    = 2048,
  parameter int unsigned AIS_WIN     = 2048,
  parameter int unsigned AIS_ZEROS   = 3,
  parameter int unsigned CHAN_BITS   = 8,
  parameter int unsigned REF_PER_BIT = 4
) (
  input  logic ref_clk,
  input  logic rx_clk,
  input  logic rst_n,
  input  logic cfg_long_run,
  input  logic cfg_nrz,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic los_clr,
  input  logic ais_clr,
  input  logic lorc_clr,
  output logic los_rt,
  output logic ais_rt,
  output logic lorc_rt,
  output logic los_evt,
  output logic ais_evt,
  output logic lorc_evt
);
  import lcm_pkg::*;

  localparam int unsigned LORC_LIMIT = CHAN_BITS * REF_PER_BIT;

  logic rx_rst_n, ref_rst_n;
  logic line_zero;
  logic los_raw, ais_raw, lorc_raw;
  logic los_ref, ais_ref;
  logic [NUM_COND-1:0] cond_vec, clr_vec, evt_vec;

  lcm_rst_sync #(.STAGES(2)) u_rx_rst (
    .clk(rx_clk), .rst_n(rst_n), .rst_n_sync(rx_rst_n));
  lcm_rst_sync #(.STAGES(2)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .rst_n_sync(ref_rst_n));

  always_comb line_zero = ~rx_pos & (cfg_nrz | ~rx_neg);

  lcm_zero_run #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_zero_run (
    .clk(rx_clk), .rst_n(rx_rst_n), .bit_zero(line_zero),
    .long_sel(cfg_long_run), .los(los_raw));

  lcm_ais_det #(.WIN(AIS_WIN), .ZMAX(AIS_ZEROS)) u_ais (
    .clk(rx_clk), .rst_n(rx_rst_n), .bit_zero(line_zero), .ais(ais_raw));

  lcm_clk_watch #(.LIMIT(LORC_LIMIT)) u_clk_watch (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .lorc(lorc_raw));

  lcm_bit_sync #(.STAGES(2)) u_los_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(los_raw), .q(los_ref));
  lcm_bit_sync #(.STAGES(2)) u_ais_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(ais_raw), .q(ais_ref));

  always_comb begin
    cond_vec[int'(COND_LOS)]  = los_ref;
    cond_vec[int'(COND_AIS)]  = ais_ref;
    cond_vec[int'(COND_LORC)] = lorc_raw;
    clr_vec[int'(COND_LOS)]   = los_clr;
    clr_vec[int'(COND_AIS)]   = ais_clr;
    clr_vec[int'(COND_LORC)]  = lorc_clr;
  end

  generate
    for (genvar i = 0; i < int'(NUM_COND); i++) begin : g_evt
      lcm_evt_latch u_latch (
        .clk(ref_clk), .rst_n(ref_rst_n),
        .cond(cond_vec[i]), .clr(clr_vec[i]), .evt(evt_vec[i]));
    end
  endgenerate

  assign los_rt   = los_raw;
  assign ais_rt   = ais_raw;
  assign lorc_rt  = lorc_raw;
  assign los_evt  = evt_vec[int'(COND_LOS)];
  assign ais_evt  = evt_vec[int'(COND_AIS)];
  assign lorc_evt = evt_vec[int'(COND_LORC)];

  a_r3_neg_rail_is_one: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (!cfg_nrz && rx_neg) |=> !los_rt);
  a_r4_nrz_pos_is_one: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (cfg_nrz && rx_pos) |=> !los_rt);
endmodule

// File: tb/sim_rx_line_mon.sv
module sim_rx_line_mon;
  localparam int REF_PERIOD = 10;
  localparam int RX_HALF    = 20;

  logic ref_clk = 1'b0;
  logic rx_clk  = 1'b0;
  logic rx_run  = 1'b1;
  logic rst_n, cfg_long_run, cfg_nrz, rx_pos, rx_neg;
  logic los_clr, ais_clr, lorc_clr;
  logic los_rt, ais_rt, lorc_rt, los_evt, ais_evt, lorc_evt;

  int checks = 0;
  int errors = 0;
  logic seen_los_evt = 1'b0;
  logic seen_lorc    = 1'b0;
  logic seen_ais_low;

  rx_line_mon u0 (
    .ref_clk(ref_clk), .rx_clk(rx_clk), .rst_n(rst_n),
    .cfg_long_run(cfg_long_run), .cfg_nrz(cfg_nrz),
    .rx_pos(rx_pos), .rx_neg(rx_neg),
    .los_clr(los_clr), .ais_clr(ais_clr), .lorc_clr(lorc_clr),
    .los_rt(los_rt), .ais_rt(ais_rt), .lorc_rt(lorc_rt),
    .los_evt(los_evt), .ais_evt(ais_evt), .lorc_evt(lorc_evt));

  always #(REF_PERIOD/2) ref_clk = ~ref_clk;
  always begin
    #(RX_HALF);
    if (rx_run) rx_clk = ~rx_clk;
  end

  always @(negedge ref_clk) begin
    if (los_evt) seen_los_evt = 1'b1;
    if (lorc_rt) seen_lorc = 1'b1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_wait(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic send_bit(input logic p, input logic n);
    @(negedge rx_clk);
    rx_pos = p;
    rx_neg = n;
    @(posedge rx_clk);
    #2;
  endtask

  task automatic track_bit(input logic p, input logic n);
    send_bit(p, n);
    if (!ais_rt) seen_ais_low = 1'b1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(REF_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_long_run = 1'b0; cfg_nrz = 1'b0;
    rx_pos = 1'b1; rx_neg = 1'b0;
    los_clr = 1'b0; ais_clr = 1'b0; lorc_clr = 1'b0;
    #(REF_PERIOD * 10 + 3);
    rst_n = 1'b1;
    ref_wait(20);

    // R10 reset state
    chk("R10 los_rt", los_rt, 0);
    chk("R10 ais_rt", ais_rt, 0);
    chk("R10 lorc_rt", lorc_rt, 0);
    chk("R10 los_evt", los_evt, 0);
    chk("R10 ais_evt", ais_evt, 0);
    chk("R10 lorc_evt", lorc_evt, 0);

    // R1 short threshold sweep, every run length 1..260
    send_bit(1'b1, 1'b0);
    for (int k = 1; k <= 260; k++) begin
      send_bit(1'b0, 1'b0);
      chk("R1 los_rt short run", los_rt, (k >= 255) ? 1 : 0);
    end
    ref_wait(8);
    chk("R8 los_evt after rise", los_evt, 1);

    // R3 one on the negative rail clears
    send_bit(1'b0, 1'b1);
    chk("R3 los_rt after neg one", los_rt, 0);

    // R9 clear only its own bit
    @(negedge ref_clk) los_clr = 1'b1;
    @(negedge ref_clk) los_clr = 1'b0;
    ref_wait(3);
    chk("R9 los_evt cleared", los_evt, 0);
    chk("R9 ais_evt untouched", ais_evt, 0);
    chk("R9 lorc_evt untouched", lorc_evt, 0);

    // R2 long threshold sweep
    cfg_long_run = 1'b1;
    send_bit(1'b1, 1'b0);
    for (int k = 1; k <= 2050; k++) begin
      send_bit(1'b0, 1'b0);
      chk("R2 los_rt long run", los_rt, (k >= 2048) ? 1 : 0);
    end
    send_bit(1'b1, 1'b0);
    chk("R3 los_rt after pos one", los_rt, 0);
    cfg_long_run = 1'b0;

    // R4 NRZ: neg rail ignored; R9 set wins while clear held
    cfg_nrz = 1'b1;
    send_bit(1'b1, 1'b0);
    @(negedge ref_clk);
    los_clr = 1'b1;
    seen_los_evt = 1'b0;
    for (int k = 1; k <= 256; k++) begin
      send_bit(1'b0, 1'b1);
      chk("R4 los_rt nrz neg ignored", los_rt, (k >= 255) ? 1 : 0);
    end
    ref_wait(8);
    chk("R9 los_evt set despite held clear", seen_los_evt, 1);
    chk("R9 los_evt cleared by held clear", los_evt, 0);
    los_clr = 1'b0;
    cfg_nrz = 1'b0;
    for (int k = 1; k <= 300; k++) begin
      send_bit(1'b0, 1'b1);
      chk("R4 los_rt bipolar neg is one", los_rt, 0);
    end

    // R5 all ones on alternating rails sets AIS
    for (int k = 1; k <= 4110; k++) send_bit(k[0], ~k[0]);
    chk("R5 ais_rt all ones", ais_rt, 1);
    ref_wait(8);
    chk("R8 ais_evt after rise", ais_evt, 1);

    // R5 two zeros never reach the limit in any window
    seen_ais_low = 1'b0;
    track_bit(1'b0, 1'b0);
    track_bit(1'b0, 1'b0);
    for (int k = 1; k <= 4100; k++) track_bit(k[0], ~k[0]);
    chk("R5 ais_rt kept with two zeros", seen_ais_low, 0);

    // R6 six zeros put at least three into one window
    seen_ais_low = 1'b0;
    for (int k = 1; k <= 6; k++) track_bit(1'b0, 1'b0);
    for (int k = 1; k <= 2070; k++) track_bit(1'b1, 1'b0);
    chk("R6 ais_rt cleared by zeros", seen_ais_low, 1);
    for (int k = 1; k <= 4100; k++) send_bit(1'b1, 1'b0);
    chk("R5 ais_rt restored", ais_rt, 1);

    // R7 short pause does not raise clock loss
    ref_wait(4);
    seen_lorc = 1'b0;
    rx_run = 1'b0;
    ref_wait(16);
    rx_run = 1'b1;
    ref_wait(40);
    chk("R7 lorc_rt short pause", seen_lorc, 0);

    // R7 long pause raises it, restart clears it
    rx_run = 1'b0;
    ref_wait(80);
    chk("R7 lorc_rt long pause", lorc_rt, 1);
    chk("R8 lorc_evt after rise", lorc_evt, 1);
    rx_run = 1'b1;
    ref_wait(20);
    chk("R7 lorc_rt after restart", lorc_rt, 0);
    chk("R8 lorc_evt holds after fall", lorc_evt, 1);

    // R9 isolation of clears
    @(negedge ref_clk) lorc_clr = 1'b1;
    @(negedge ref_clk) lorc_clr = 1'b0;
    ref_wait(3);
    chk("R9 lorc_evt cleared", lorc_evt, 0);
    chk("R9 ais_evt kept on lorc clear", ais_evt, 1);
    @(negedge ref_clk) ais_clr = 1'b1;
    @(negedge ref_clk) ais_clr = 1'b0;
    ref_wait(3);
    chk("R9 ais_evt cleared", ais_evt, 0);
    chk("R9 lorc_evt stays clear", lorc_evt, 0);

    finish_run();
  end
endmodule